// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Divider

This block divides one 32-bit binary floating-point operand by another and returns the correctly rounded single-precision quotient. A caller presents both operands with a one-cycle start strobe while the block is idle. The block captures the operands and then works through the significand quotient with a restoring divider that resolves one quotient bit per clock. A separate path subtracts the biased exponents and adds the bias back. A final cycle selects between the rounded arithmetic result and the special-value results, and pulses done.

The quotient is carried three bits beyond the 24-bit significand. When the dividend significand is the smaller of the two, the extra leading position is zero and the quotient is shifted up one place. The bits that fall below the kept significand and the nonzero state of the last partial remainder then decide rounding to nearest, with ties to even. Subnormal operands and results are flushed to signed zero. NaN and infinity operands, and division by zero, each get their own result and flag.

Top module: `fdiv_seq`

## Requirements
- R1: After reset, busy, done, result, div_zero and invalid are all 0. When start is high at an edge while busy is low, busy is high for the next 28 cycles and is low in the cycle after them. In that cycle done is high for exactly one cycle, and result and flags are valid.
- R2: The operands are captured at the edge that accepts start, so later changes on op_a and op_b do not affect the result. Start is ignored while busy is high.
- R3: Operands and result use the single-precision layout: bit 31 is the sign, bits 30:23 are the biased exponent (bias 127) and bits 22:0 are the fraction with a hidden leading 1. For normal operands, the result sign is the XOR of the operand signs and the result exponent is E_a − E_b + 127.
- R4: When the dividend significand is smaller than the divisor significand, the quotient is renormalized by one place and the result exponent is reduced by one.
- R5: The 24-bit significand is rounded to nearest, with ties to even. The dropped quotient bits and a nonzero final remainder count toward the rounding decision. A carry out of rounding raises the exponent by one.
- R6: If the exponent after rounding is 255 or more, the result is signed infinity (exponent 255, fraction 0) and no flag is raised.
- R7: If the exponent after rounding is 0 or less, the result is signed zero. An operand with exponent field 0 is treated as zero, whatever its fraction.
- R8: A finite nonzero dividend divided by a zero divisor gives signed infinity and sets div_zero.
- R9: Any NaN operand (exponent 255, fraction nonzero), 0/0 or ∞/∞ gives 0x7FC00000 and sets invalid; div_zero stays 0.
- R10: Zero divided by a nonzero value, or a finite value divided by infinity, gives signed zero. Infinity divided by a finite value (zero included) gives signed infinity. Neither flag is set in these cases.
- R11: Result, div_zero and invalid change only in the cycle where done is high, and hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; accepted only while busy is low |
| op_a | input | 32 | Dividend, single precision |
| op_b | input | 32 | Divisor, single precision |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: result and flags are valid |
| result | output | 32 | Quotient, single precision |
| div_zero | output | 1 | Finite nonzero value was divided by zero |
| invalid | output | 1 | Invalid operation; result is the quiet NaN |

## Verification
The bench builds the block with its default widths, an 8-bit exponent and a 23-bit fraction, so every operand is an ordinary single-precision word. That lets a reference model in the bench compute each expected quotient with 64-bit integer division and an exact remainder-against-half-divisor comparison. With these widths, random exponents spread across the whole 1..254 range produce overflow, underflow and rounding-carry cases naturally, next to the directed renormalization, special-value and ignored-start runs.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } fdiv_state_e;

    typedef struct packed {
        logic is_nan;
        logic is_inf;
        logic is_zero;
    } fdiv_class_t;

endpackage

// File: rtl/fdiv_unpack.sv
// Splits one operand into sign, biased exponent and significand with the
// hidden bit restored; subnormals are reported as zero.
module fdiv_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0]  op,
    output logic                   sign,
    output logic [EXP_W-1:0]       exp_b,
    output logic [FRAC_W:0]        mant,
    output fdiv_pkg::fdiv_class_t  cls
);

    logic [EXP_W-1:0]  e_fld;
    logic [FRAC_W-1:0] f_fld;
    logic              e_all1;
    logic              e_all0;

    always_comb begin
        e_fld       = op[EXP_W+FRAC_W-1 -: EXP_W];
        f_fld       = op[FRAC_W-1:0];
        sign        = op[EXP_W+FRAC_W];
        e_all1      = &e_fld;
        e_all0      = ~|e_fld;
        cls.is_nan  = e_all1 & (|f_fld);
        cls.is_inf  = e_all1 & ~(|f_fld);
        cls.is_zero = e_all0;
        exp_b       = e_fld;
        mant        = e_all0 ? '0 : {1'b1, f_fld};
    end

endmodule

// File: rtl/fdiv_step.sv
// One restoring division step: compare, conditionally subtract, shift.
module fdiv_step #(
    parameter int SIG_W = 24
) (
    input  logic [SIG_W:0]   rem_in,
    input  logic [SIG_W-1:0] dvsr,
    output logic             q_bit,
    output logic [SIG_W:0]   rem_out
);

    logic [SIG_W:0] dvsr_ext;
    logic [SIG_W:0] diff;
    logic [SIG_W:0] kept;

    always_comb begin
        dvsr_ext = {1'b0, dvsr};
        diff     = rem_in - dvsr_ext;
        q_bit    = (rem_in >= dvsr_ext);
        kept     = q_bit ? diff : rem_in;
        rem_out  = kept << 1;
    end

endmodule

// File: rtl/fdiv_round.sv
// Normalizes the raw quotient, rounds to nearest-even and packs the word,
// saturating to infinity or flushing to zero at the exponent limits.
module fdiv_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [FRAC_W+3:0]         quo,
    input  logic                      rem_nz,
    input  logic                      sign,
    input  logic signed [EXP_W+1:0]   exp_pre,
    output logic [EXP_W+FRAC_W:0]     packed_res
);

    localparam int SIG_W = FRAC_W + 1;
    localparam int QB    = SIG_W + 3;
    localparam int EW    = EXP_W + 2;
    localparam logic signed [EW-1:0] ONE_S  = EW'(1);
    localparam logic signed [EW-1:0] ZERO_S = '0;
    localparam logic signed [EW-1:0] EMAX_S = EW'((1 << EXP_W) - 1);

    logic                   lead;
    logic [SIG_W-1:0]       sig_raw;
    logic                   g_bit;
    logic                   r_bit;
    logic                   s_bit;
    logic                   inc;
    logic [SIG_W:0]         sum;
    logic signed [EW-1:0]   e_n;
    logic signed [EW-1:0]   e_r;
    logic [FRAC_W-1:0]      frac;

    always_comb begin
        lead    = quo[QB-1];
        sig_raw = lead ? quo[QB-1 -: SIG_W] : quo[QB-2 -: SIG_W];
        g_bit   = lead ? quo[2] : quo[1];
        r_bit   = lead ? quo[1] : quo[0];
        s_bit   = lead ? (quo[0] | rem_nz) : rem_nz;
        e_n     = lead ? exp_pre : (exp_pre - ONE_S);
        inc     = g_bit & (r_bit | s_bit | sig_raw[0]);
        sum     = {1'b0, sig_raw} + {{SIG_W{1'b0}}, inc};
        if (sum[SIG_W]) begin
            e_r  = e_n + ONE_S;
            frac = sum[SIG_W-1:1];
        end else begin
            e_r  = e_n;
            frac = sum[FRAC_W-1:0];
        end
        if (e_r >= EMAX_S) begin
            packed_res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (e_r <= ZERO_S) begin
            packed_res = {sign, {(EXP_W+FRAC_W){1'b0}}};
        end else begin
            packed_res = {sign, e_r[EXP_W-1:0], frac};
        end
    end

endmodule

// File: rtl/fdiv_seq.sv
// Iterative single-precision divider: one quotient bit per clock.
module fdiv_seq
    import fdiv_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [EXP_W+FRAC_W:0]  op_a,
    input  logic [EXP_W+FRAC_W:0]  op_b,
    output logic                   busy,
    output logic                   done,
    output logic [EXP_W+FRAC_W:0]  result,
    output logic                   div_zero,
    output logic                   invalid
);

    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int SIG_W = FRAC_W + 1;
    localparam int QB    = SIG_W + 3;
    localparam int CNT_W = $clog2(QB + 1);
    localparam int EW    = EXP_W + 2;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam logic signed [EW-1:0] BIAS_S = EW'(BIAS);
    localparam logic [CNT_W-1:0]     LAST   = CNT_W'(QB - 1);
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    typedef struct packed {
        fdiv_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     opa;
        logic [W-1:0]     opb;
        logic [SIG_W:0]   rem;
        logic [QB-1:0]    quo;
        logic [W-1:0]     res;
        logic             dz;
        logic             inv;
        logic             done;
    } regs_t;

    regs_t q_q;
    regs_t q_d;

    // operand decode, one instance per operand
    logic [W-1:0]      opnd   [2];
    logic              sgn    [2];
    logic [EXP_W-1:0]  ex     [2];
    logic [SIG_W-1:0]  mt     [2];
    fdiv_class_t       cl     [2];

    always_comb begin
        opnd[0] = q_q.opa;
        opnd[1] = q_q.opb;
    end

    for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
        fdiv_unpack #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_unpack (
            .op    (opnd[gi]),
            .sign  (sgn[gi]),
            .exp_b (ex[gi]),
            .mant  (mt[gi]),
            .cls   (cl[gi])
        );
    end

    // significand iteration
    logic [SIG_W:0] step_in;
    logic [SIG_W:0] step_out;
    logic           step_bit;

    always_comb begin
        step_in = (q_q.cnt == '0) ? {1'b0, mt[0]} : q_q.rem;
    end

    fdiv_step #(
        .SIG_W (SIG_W)
    ) u_step (
        .rem_in  (step_in),
        .dvsr    (mt[1]),
        .q_bit   (step_bit),
        .rem_out (step_out)
    );

    // exponent and rounding
    logic signed [EW-1:0] exp_pre;
    logic                 res_sign;
    logic                 rem_nz;
    logic [W-1:0]         rnd_res;

    always_comb begin
        exp_pre  = $signed({2'b00, ex[0]}) - $signed({2'b00, ex[1]}) + BIAS_S;
        res_sign = sgn[0] ^ sgn[1];
        rem_nz   = |q_q.rem;
    end

    fdiv_round #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_round (
        .quo        (q_q.quo),
        .rem_nz     (rem_nz),
        .sign       (res_sign),
        .exp_pre    (exp_pre),
        .packed_res (rnd_res)
    );

    // special-value selection
    logic         is_invalid;
    logic [W-1:0] final_res;
    logic         final_dz;

    always_comb begin
        is_invalid = cl[0].is_nan | cl[1].is_nan
                   | (cl[0].is_zero & cl[1].is_zero)
                   | (cl[0].is_inf  & cl[1].is_inf);
        final_dz   = 1'b0;
        if (is_invalid) begin
            final_res = QNAN;
        end else if (cl[0].is_inf) begin
            final_res = {res_sign, INF_MAG};
        end else if (cl[1].is_zero) begin
            final_res = {res_sign, INF_MAG};
            final_dz  = 1'b1;
        end else if (cl[0].is_zero | cl[1].is_inf) begin
            final_res = {res_sign, {(W-1){1'b0}}};
        end else begin
            final_res = rnd_res;
        end
    end

    // next-state computation
    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        unique case (q_q.st)
            ST_IDLE: begin
                if (start) begin
                    q_d.opa = op_a;
                    q_d.opb = op_b;
                    q_d.cnt = '0;
                    q_d.st  = ST_RUN;
                end
            end
            ST_RUN: begin
                q_d.rem = step_out;
                q_d.quo = {q_q.quo[QB-2:0], step_bit};
                q_d.cnt = q_q.cnt + 1'b1;
                if (q_q.cnt == LAST) begin
                    q_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                q_d.res  = final_res;
                q_d.dz   = final_dz;
                q_d.inv  = is_invalid;
                q_d.done = 1'b1;
                q_d.st   = ST_IDLE;
            end
            default: begin
                q_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    always_comb begin
        busy     = (q_q.st != ST_IDLE);
        done     = q_q.done;
        result   = q_q.res;
        div_zero = q_q.dz;
        invalid  = q_q.inv;
    end

endmodule

// File: rtl/fdiv_seq_chk.sv
module fdiv_seq_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  done,
    input logic [EXP_W+FRAC_W:0] result,
    input logic                  div_zero,
    input logic                  invalid
);

    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int QB    = FRAC_W + 4;
    localparam int BC_W  = $clog2(QB + 2) + 1;
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    logic [BC_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (!busy) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    // R1
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R1
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == BC_W'(QB + 1)));

    // R2
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R9
    nan_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && invalid) |-> (result == QNAN) && !div_zero);

    // R8
    dz_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (result[W-2:0] == INF_MAG));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

endmodule

bind fdiv_seq fdiv_seq_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/fdiv_seq_bench.sv
`timescale 1ns/1ps
module fdiv_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        busy;
    logic        done;
    logic [31:0] result;
    logic        div_zero;
    logic        invalid;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    fdiv_seq u_fdiv_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_a     (op_a),
        .op_b     (op_b),
        .busy     (busy),
        .done     (done),
        .result   (result),
        .div_zero (div_zero),
        .invalid  (invalid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference: {invalid, div_zero, result}
    function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b);
        int ea, eb, e;
        logic s;
        bit an, ai, az, bn, bi, bz;
        longint unsigned ma, mb, num, qq, rr;
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        s  = a[31] ^ b[31];
        an = (ea == 255) && (a[22:0] != 0);
        ai = (ea == 255) && (a[22:0] == 0);
        az = (ea == 0);
        bn = (eb == 255) && (b[22:0] != 0);
        bi = (eb == 255) && (b[22:0] == 0);
        bz = (eb == 0);
        if (an || bn || (az && bz) || (ai && bi)) return {2'b10, 32'h7FC00000};
        if (ai) return {2'b00, s, 8'hFF, 23'h0};
        if (bz) return {2'b01, s, 8'hFF, 23'h0};
        if (az || bi) return {2'b00, s, 31'h0};
        ma = 64'(a[22:0]) | 64'h800000;
        mb = 64'(b[22:0]) | 64'h800000;
        e  = ea - eb + 127;
        if (ma < mb) begin
            num = ma << 24;
            e   = e - 1;
        end else begin
            num = ma << 23;
        end
        qq = num / mb;
        rr = num % mb;
        if ((2 * rr > mb) || ((2 * rr == mb) && qq[0])) qq = qq + 1;
        if (qq == 64'h1000000) begin
            qq = 64'h800000;
            e  = e + 1;
        end
        if (e >= 255) return {2'b00, s, 8'hFF, 23'h0};
        if (e <= 0) return {2'b00, s, 31'h0};
        return {2'b00, s, e[7:0], qq[22:0]};
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input string req, input bit poke);
        logic [33:0] ex;
        ex = model(a, b);
        @(negedge clk);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_a  = ~a;            // R2: inputs change after acceptance
        op_b  = ~b;
        chk(busy == 1'b1, "R1", "busy after accept", 32'(busy), 32'd1);
        for (int k = 1; k <= 28; k++) begin
            if (poke && k == 5) begin
                start = 1'b1;  // R2: start while busy must be ignored
                op_a  = 32'h40400000;
                op_b  = 32'h3F800000;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            chk(busy == (k <= 27), "R1", "busy window", 32'(busy), 32'(k <= 27));
            chk(done == (k == 28), "R1", "done timing", 32'(done), 32'(k == 28));
            if (k == 28) begin
                chk(result == ex[31:0], req, "result", result, ex[31:0]);
                chk(div_zero == ex[32], req, "div_zero", 32'(div_zero), 32'(ex[32]));
                chk(invalid == ex[33], req, "invalid", 32'(invalid), 32'(ex[33]));
            end
        end
        @(negedge clk);
        chk(!done, "R1", "done single pulse", 32'(done), 32'd0);
        chk(!busy, "R2", "no restart from ignored start", 32'(busy), 32'd0);
        chk(result == ex[31:0], "R11", "result held", result, ex[31:0]);
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL R1 watchdog expired: actual=%h expected=%h", 32'd0, 32'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy, "R1", "reset busy", 32'(busy), 32'd0);
        chk(!done, "R1", "reset done", 32'(done), 32'd0);
        chk(result == 32'h0, "R1", "reset result", result, 32'h0);
        chk(!div_zero && !invalid, "R1", "reset flags", 32'({div_zero, invalid}), 32'd0);
        rst_n = 1'b1;

        // R3 normal quotients
        run_op(32'h40C00000, 32'h40400000, "R3", 1'b0);
        run_op(32'hBFC00000, 32'h3F000000, "R3", 1'b0);
        run_op(32'h3F800000, 32'h3F800000, "R3", 1'b0);
        // R2 ignored start during busy
        run_op(32'h41200000, 32'h40800000, "R2", 1'b1);
        // R4 renormalization
        run_op(32'h3F800000, 32'h40400000, "R4", 1'b0);
        run_op(32'h40000000, 32'hC0400000, "R4", 1'b0);
        // R5 rounding
        run_op(32'h3F800000, 32'h40E00000, "R5", 1'b0);
        run_op(32'h3F800000, 32'h40A00000, "R5", 1'b0);
        run_op(32'h3FFFFFFF, 32'h3F800001, "R5", 1'b0);
        // R6 overflow
        run_op(32'h7F7FFFFF, 32'h3F000000, "R6", 1'b0);
        run_op(32'h7F000000, 32'h00800000, "R6", 1'b0);
        // R7 underflow and flushed subnormals
        run_op(32'h00800000, 32'h7F000000, "R7", 1'b0);
        run_op(32'h00800000, 32'h3F800001, "R7", 1'b0);
        run_op(32'h00000001, 32'h3F800000, "R7", 1'b0);
        // R8 divide by zero (subnormal divisor counts as zero)
        run_op(32'h3F800000, 32'h00000000, "R8", 1'b0);
        run_op(32'hBF800000, 32'h00000000, "R8", 1'b0);
        run_op(32'h3F800000, 32'h00000005, "R8", 1'b0);
        // R9 invalid
        run_op(32'h7F800001, 32'h3F800000, "R9", 1'b0);
        run_op(32'h3F800000, 32'hFFC00000, "R9", 1'b0);
        run_op(32'h00000000, 32'h80000000, "R9", 1'b0);
        run_op(32'h7F800000, 32'hFF800000, "R9", 1'b0);
        // R10 exact specials
        run_op(32'h00000000, 32'h40A00000, "R10", 1'b0);
        run_op(32'h80000000, 32'h40A00000, "R10", 1'b0);
        run_op(32'h3F800000, 32'hFF800000, "R10", 1'b0);
        run_op(32'h7F800000, 32'h40000000, "R10", 1'b0);
        run_op(32'hFF800000, 32'h00000000, "R10", 1'b0);

        // R3/R5/R6/R7 random normal operands over the full exponent range
        for (int i = 0; i < 60; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            ra = {1'($urandom % 2), 8'(1 + ($urandom % 254)), 23'($urandom)};
            rb = {1'($urandom % 2), 8'(1 + ($urandom % 254)), 23'($urandom)};
            run_op(ra, rb, "R3", 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule